// File: doc/BRIEF.md
# Cache-Aware Page Walker

This block handles TLB misses in a system where an in-package DRAM cache holds whole pages. A miss names the address of a page table entry and the core that missed. The walker fetches that entry, which holds an address field and three flag bits. It waits until the entry is unlocked, locks it with a compare-and-swap, and then picks one of three outcomes. A page marked non-cacheable returns its physical address. A page already resident returns the cache address stored in the entry. A page that is neither gets a new cache block from the cache directory, and its entry is rewritten in place to point at that block.

The walker then writes the entry back with the lock cleared. It delivers a single-cycle TLB fill with the result address and the non-cacheable flag. On either cached outcome it tells the directory to mark the requesting core as a holder of that block. Only one miss is in flight at a time. Table traversal is reduced to one entry fetch.

Top module: `cache_walker`

## Requirements
- R1: After reset, `miss_ready` is 1 and `mem_req`, `alloc_req`, `fill_valid` and `res_set` are 0.
- R2: A miss is accepted only while `miss_ready` is 1. `miss_ready` stays 0 from acceptance until the fill has been issued, and a miss presented in that window has no effect on any entry or fill.
- R3: Entry layout, with A = ADDR_W: bits [A-1:0] hold the address, bit A is valid-in-cache, bit A+1 is non-cacheable, and bit A+2 is the lock. The walker reads the entry (`mem_op` 0 = read). While the lock bit it reads is 1, it reads again and issues no other memory operation.
- R4: The lock is taken with `mem_op` 2 (compare-and-swap). The compare value is the read entry with the lock at 0, and the swap value is the same entry with the lock at 1. The swap succeeds only when the returned old value equals the compare value. On failure the walker goes back to reading.
- R5: When the non-cacheable bit is 1, whatever valid-in-cache holds, the fill carries the entry's address field with `fill_nc`=1 and `fill_cached`=0. No allocation and no residence command are issued, and the entry ends identical to its unlocked original.
- R6: When both flag bits are 0, `alloc_req` carries the entry's physical address and the entry address. After `alloc_gnt`, the entry is rewritten with address = granted cache address, valid-in-cache = 1, non-cacheable = 0 and lock = 0. The fill carries the granted address.
- R7: When valid-in-cache is 1 and non-cacheable is 0, the fill carries the address field with `fill_cached`=1, no allocation is requested, and the entry ends unchanged apart from the lock.
- R8: On a cached outcome, `res_set` pulses in the same cycle as `fill_valid`, with `res_block` equal to the fill address and `res_core` equal to the requesting core.
- R9: The unlock write (`mem_op` 1) always has the lock bit 0. The fill follows its acknowledge and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle, miss accepted this cycle |
| miss_pte_addr | input | PTE_AW | Address of the page table entry |
| miss_core | input | CORE_W | Core that missed |
| mem_req | output | 1 | Memory operation request, held until acknowledged |
| mem_op | output | 2 | 0 read, 1 write, 2 compare-and-swap |
| mem_addr | output | PTE_AW | Entry address |
| mem_wdata | output | ADDR_W+3 | Write value or swap value |
| mem_cmp | output | ADDR_W+3 | Compare value for compare-and-swap |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | ADDR_W+3 | Read data, or old value for compare-and-swap |
| alloc_req | output | 1 | Cache block request, held until granted |
| alloc_phys | output | ADDR_W | Physical address of the page being cached |
| alloc_pte | output | PTE_AW | Entry address for the directory record |
| alloc_gnt | input | 1 | One-cycle grant |
| alloc_cache_addr | input | ADDR_W | Granted cache block address |
| fill_valid | output | 1 | One-cycle TLB fill |
| fill_addr | output | ADDR_W | Physical or cache address |
| fill_nc | output | 1 | Non-cacheable flag from the entry |
| fill_cached | output | 1 | Fill address is a cache address |
| res_set | output | 1 | Set residence bit command |
| res_block | output | ADDR_W | Cache block for the residence command |
| res_core | output | CORE_W | Core whose residence bit is set |

## Verification
The assertions assume that `mem_ack` and `alloc_gnt` are single-cycle pulses that come only while the matching request is held. They also assume that memory honours compare-and-swap atomically. The bench responders enforce this: each acknowledges at most once per held request, one cycle after it sees the request. Lock contention and a lock stolen between the read and the swap are produced inside the memory responder itself. They are released only through its host write path, so memory is never changed outside a clock edge.

// File: rtl/walk_pkg.sv
package walk_pkg;
    typedef enum logic [1:0] {
        MOP_READ  = 2'd0,
        MOP_WRITE = 2'd1,
        MOP_CAS   = 2'd2
    } mem_op_e;

    typedef enum logic [1:0] {
        OUT_PHYS,
        OUT_HIT,
        OUT_ALLOC
    } outcome_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_LOCK,
        S_ALLOC,
        S_UNLOCK,
        S_FILL
    } walk_st_e;
endpackage

// File: rtl/walk_entry_view.sv
module walk_entry_view #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W+1:0] entry,
    output logic [ADDR_W-1:0] addr,
    output logic              vc,
    output logic              nc
);
    assign addr = entry[ADDR_W-1:0];
    assign vc   = entry[ADDR_W];
    assign nc   = entry[ADDR_W+1];
endmodule

// File: rtl/walk_outcome.sv
module walk_outcome
    import walk_pkg::*;
(
    input  logic     nc,
    input  logic     vc,
    output outcome_e sel
);
    always_comb begin
        if (nc)      sel = OUT_PHYS;
        else if (vc) sel = OUT_HIT;
        else         sel = OUT_ALLOC;
    end
endmodule

// File: rtl/cache_walker.sv
module cache_walker
    import walk_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int PTE_AW = 16,
    parameter int CORE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [PTE_AW-1:0] miss_pte_addr,
    input  logic [CORE_W-1:0] miss_core,
    output logic              mem_req,
    output logic [1:0]        mem_op,
    output logic [PTE_AW-1:0] mem_addr,
    output logic [ADDR_W+2:0] mem_wdata,
    output logic [ADDR_W+2:0] mem_cmp,
    input  logic              mem_ack,
    input  logic [ADDR_W+2:0] mem_rdata,
    output logic              alloc_req,
    output logic [ADDR_W-1:0] alloc_phys,
    output logic [PTE_AW-1:0] alloc_pte,
    input  logic              alloc_gnt,
    input  logic [ADDR_W-1:0] alloc_cache_addr,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic              fill_nc,
    output logic              fill_cached,
    output logic              res_set,
    output logic [ADDR_W-1:0] res_block,
    output logic [CORE_W-1:0] res_core
);
    localparam int ENT_W  = ADDR_W + 3;
    localparam int PU_BIT = ADDR_W + 2;

    typedef struct packed {
        walk_st_e          st;
        logic [PTE_AW-1:0] pte_addr;
        logic [CORE_W-1:0] core;
        logic [ENT_W-1:0]  entry;
        logic [ADDR_W-1:0] result;
        logic              cached;
    } walk_state_t;

    walk_state_t state_d, state_q;

    logic [ADDR_W-1:0] ent_addr;
    logic              ent_vc;
    logic              ent_nc;
    outcome_e          pick;
    logic [ENT_W-1:0]  ent_free;
    logic [ENT_W-1:0]  ent_held;

    walk_entry_view #(.ADDR_W(ADDR_W)) u_view (
        .entry (state_q.entry[ADDR_W+1:0]),
        .addr  (ent_addr),
        .vc    (ent_vc),
        .nc    (ent_nc)
    );

    walk_outcome u_pick (
        .nc  (ent_nc),
        .vc  (ent_vc),
        .sel (pick)
    );

    assign ent_free = {1'b0, ent_nc, ent_vc, ent_addr};
    assign ent_held = {1'b1, ent_nc, ent_vc, ent_addr};

    always_comb begin
        state_d     = state_q;
        miss_ready  = 1'b0;
        mem_req     = 1'b0;
        mem_op      = MOP_READ;
        mem_addr    = state_q.pte_addr;
        mem_wdata   = '0;
        mem_cmp     = '0;
        alloc_req   = 1'b0;
        alloc_phys  = ent_addr;
        alloc_pte   = state_q.pte_addr;
        fill_valid  = 1'b0;
        fill_addr   = state_q.result;
        fill_nc     = ent_nc;
        fill_cached = state_q.cached;
        res_set     = 1'b0;
        res_block   = state_q.result;
        res_core    = state_q.core;

        unique case (state_q.st)
            S_IDLE: begin
                miss_ready = 1'b1;
                if (miss_valid) begin
                    state_d.pte_addr = miss_pte_addr;
                    state_d.core     = miss_core;
                    state_d.st       = S_READ;
                end
            end
            S_READ: begin
                mem_req = 1'b1;
                mem_op  = MOP_READ;
                if (mem_ack && !mem_rdata[PU_BIT]) begin
                    state_d.entry = mem_rdata;
                    state_d.st    = S_LOCK;
                end
            end
            S_LOCK: begin
                mem_req   = 1'b1;
                mem_op    = MOP_CAS;
                mem_cmp   = ent_free;
                mem_wdata = ent_held;
                if (mem_ack) begin
                    if (mem_rdata == ent_free) begin
                        state_d.result = ent_addr;
                        unique case (pick)
                            OUT_PHYS: begin
                                state_d.cached = 1'b0;
                                state_d.st     = S_UNLOCK;
                            end
                            OUT_HIT: begin
                                state_d.cached = 1'b1;
                                state_d.st     = S_UNLOCK;
                            end
                            default: state_d.st = S_ALLOC;
                        endcase
                    end else begin
                        state_d.st = S_READ;
                    end
                end
            end
            S_ALLOC: begin
                alloc_req = 1'b1;
                if (alloc_gnt) begin
                    state_d.result = alloc_cache_addr;
                    state_d.cached = 1'b1;
                    state_d.entry  = {1'b0, 1'b0, 1'b1, alloc_cache_addr};
                    state_d.st     = S_UNLOCK;
                end
            end
            S_UNLOCK: begin
                mem_req   = 1'b1;
                mem_op    = MOP_WRITE;
                mem_wdata = ent_free;
                if (mem_ack) state_d.st = S_FILL;
            end
            S_FILL: begin
                fill_valid = 1'b1;
                res_set    = state_q.cached;
                state_d.st = S_IDLE;
            end
            default: state_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= '0;
            state_q.st     <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/cache_walker_chk.sv
module cache_walker_chk
    import walk_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int PTE_AW = 16,
    parameter int CORE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_ready,
    input logic              mem_req,
    input logic [1:0]        mem_op,
    input logic [ADDR_W+2:0] mem_wdata,
    input logic [ADDR_W+2:0] mem_cmp,
    input logic              alloc_req,
    input logic              fill_valid,
    input logic              fill_nc,
    input logic              fill_cached,
    input logic              res_set
);
    localparam int PU_BIT = ADDR_W + 2;

    // R2
    busy_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !miss_ready);

    // R2
    busy_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> !miss_ready && !mem_req);

    // R4
    cas_lock_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_op == MOP_CAS) |-> (!mem_cmp[PU_BIT] && mem_wdata[PU_BIT]));

    // R9
    unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_op == MOP_WRITE) |-> !mem_wdata[PU_BIT]);

    // R9
    fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);

    // R5
    nc_no_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_nc) |-> (!res_set && !fill_cached));

    // R8
    res_with_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_set |-> (fill_valid && fill_cached));
endmodule

bind cache_walker cache_walker_chk #(
    .ADDR_W(ADDR_W),
    .PTE_AW(PTE_AW),
    .CORE_W(CORE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_ready  (miss_ready),
    .mem_req     (mem_req),
    .mem_op      (mem_op),
    .mem_wdata   (mem_wdata),
    .mem_cmp     (mem_cmp),
    .alloc_req   (alloc_req),
    .fill_valid  (fill_valid),
    .fill_nc     (fill_nc),
    .fill_cached (fill_cached),
    .res_set     (res_set)
);

// File: tb/cache_walker_test.sv
module cache_walker_test;
    localparam int AW = 20;
    localparam int PW = 16;
    localparam int CW = 2;
    localparam int EW = AW + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic          miss_ready;
    logic [PW-1:0] miss_pte_addr = '0;
    logic [CW-1:0] miss_core = '0;
    logic          mem_req;
    logic [1:0]    mem_op;
    logic [PW-1:0] mem_addr;
    logic [EW-1:0] mem_wdata, mem_cmp;
    logic          mem_ack;
    logic [EW-1:0] mem_rdata;
    logic          alloc_req;
    logic [AW-1:0] alloc_phys;
    logic [PW-1:0] alloc_pte;
    logic          alloc_gnt;
    logic [AW-1:0] alloc_cache_addr;
    logic          fill_valid;
    logic [AW-1:0] fill_addr;
    logic          fill_nc, fill_cached, res_set;
    logic [AW-1:0] res_block;
    logic [CW-1:0] res_core;

    always #5 clk = ~clk;

    cache_walker #(.ADDR_W(AW), .PTE_AW(PW), .CORE_W(CW)) uut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_pte_addr(miss_pte_addr), .miss_core(miss_core),
        .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_cmp(mem_cmp),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .alloc_req(alloc_req), .alloc_phys(alloc_phys), .alloc_pte(alloc_pte),
        .alloc_gnt(alloc_gnt), .alloc_cache_addr(alloc_cache_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_nc(fill_nc),
        .fill_cached(fill_cached), .res_set(res_set),
        .res_block(res_block), .res_core(res_core)
    );

    // memory model with host write path and one-shot lock steal
    logic [EW-1:0] mem [16];
    logic          host_we = 1'b0;
    logic [3:0]    host_idx = '0;
    logic [EW-1:0] host_data = '0;
    int            steal_req = 0;
    int            steal_done = 0;
    int            cas_cnt = 0;
    int            wr_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (host_we) mem[host_idx] <= host_data;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                case (mem_op)
                    2'd0: mem_rdata <= mem[mem_addr[3:0]];
                    2'd1: begin
                        mem[mem_addr[3:0]] <= mem_wdata;
                        wr_cnt <= wr_cnt + 1;
                    end
                    default: begin
                        cas_cnt <= cas_cnt + 1;
                        if (steal_req != steal_done) begin
                            steal_done <= steal_done + 1;
                            mem[mem_addr[3:0]] <= mem[mem_addr[3:0]] | (EW'(1) << (AW + 2));
                            mem_rdata <= mem[mem_addr[3:0]] | (EW'(1) << (AW + 2));
                        end else begin
                            mem_rdata <= mem[mem_addr[3:0]];
                            if (mem[mem_addr[3:0]] == mem_cmp) mem[mem_addr[3:0]] <= mem_wdata;
                        end
                    end
                endcase
            end
        end
    end

    // directory model
    logic [AW-1:0] next_blk;
    int            alloc_cnt = 0;
    logic [AW-1:0] last_phys;
    logic [PW-1:0] last_pte;

    always @(posedge clk) begin
        if (!rst_n) begin
            alloc_gnt        <= 1'b0;
            alloc_cache_addr <= '0;
            next_blk         <= AW'('h100);
        end else begin
            alloc_gnt <= 1'b0;
            if (alloc_req && !alloc_gnt) begin
                alloc_gnt        <= 1'b1;
                alloc_cache_addr <= next_blk;
                next_blk         <= next_blk + 1'b1;
                alloc_cnt        <= alloc_cnt + 1;
                last_phys        <= alloc_phys;
                last_pte         <= alloc_pte;
            end
        end
    end

    int n_checks = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [3:0] idx, input logic [EW-1:0] val);
        @(negedge clk);
        host_we = 1'b1; host_idx = idx; host_data = val;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic send_miss(input logic [3:0] idx, input logic [CW-1:0] core);
        @(negedge clk);
        miss_valid = 1'b1; miss_pte_addr = PW'(idx); miss_core = core;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    // sample at negedge; returns 1 if fill seen within limit
    task automatic wait_fill(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit && !seen; i++) begin
            if (fill_valid) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [EW-1:0] init;
        logic [3:0]    idx;
        logic [CW-1:0] core;
        logic [AW-1:0] addr;
        logic          nc;
        logic          cached;
        logic [EW-1:0] after;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{23'h212345, 4'd1, 2'd1, 20'h12345, 1'b1, 1'b0, 23'h212345}, // R5 non-cacheable
        '{23'h1000A7, 4'd2, 2'd2, 20'h000A7, 1'b0, 1'b1, 23'h1000A7}, // R7 hit
        '{23'h055555, 4'd3, 2'd3, 20'h00100, 1'b0, 1'b1, 23'h100100}, // R6 allocate
        '{23'h3ABCDE, 4'd4, 2'd0, 20'hABCDE, 1'b1, 1'b0, 23'h3ABCDE}, // R5 nc beats vc
        '{23'h0FFFFF, 4'd5, 2'd0, 20'h00101, 1'b0, 1'b1, 23'h100101}, // R6 allocate
        '{23'h100100, 4'd3, 2'd1, 20'h00100, 1'b0, 1'b1, 23'h100100}  // R7 hit after alloc
    };

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit seen;
        int a0, c0, w0;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(miss_ready == 1'b1, "R1 miss_ready", 64'(miss_ready), 1);
        check({mem_req, alloc_req, fill_valid, res_set} == 4'b0, "R1 outputs idle",
              64'({mem_req, alloc_req, fill_valid, res_set}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(miss_ready == 1'b1 && !mem_req, "R1 after release", 64'(miss_ready), 1);

        // vector table
        for (int v = 0; v < NV; v++) begin
            host_write(VECS[v].idx, VECS[v].init);
            a0 = alloc_cnt;
            send_miss(VECS[v].idx, VECS[v].core);
            wait_fill(200, seen);
            check(seen, "R9 fill arrives", 64'(seen), 1);
            check(fill_addr == VECS[v].addr, "R5/R6/R7 fill_addr", 64'(fill_addr), 64'(VECS[v].addr));
            check(fill_nc == VECS[v].nc, "R5 fill_nc", 64'(fill_nc), 64'(VECS[v].nc));
            check(fill_cached == VECS[v].cached, "R7 fill_cached", 64'(fill_cached), 64'(VECS[v].cached));
            if (VECS[v].cached)
                check(res_set && res_block == VECS[v].addr && res_core == VECS[v].core, "R8 residence",
                      64'({res_set, res_core, res_block}), 64'({1'b1, VECS[v].core, VECS[v].addr}));
            else
                check(!res_set, "R5 no residence", 64'(res_set), 0);
            @(negedge clk);
            check(!fill_valid, "R9 single-cycle fill", 64'(fill_valid), 0);
            check(mem[VECS[v].idx] == VECS[v].after, "R6 entry after walk",
                  64'(mem[VECS[v].idx]), 64'(VECS[v].after));
            if (!VECS[v].nc && !VECS[v].init[AW]) begin
                check(alloc_cnt == a0 + 1, "R6 one allocation", 64'(alloc_cnt - a0), 1);
                check(last_phys == VECS[v].init[AW-1:0] && last_pte == PW'(VECS[v].idx), "R6 alloc fields",
                      64'({last_phys, last_pte}), 64'({VECS[v].init[AW-1:0], PW'(VECS[v].idx)}));
            end else begin
                check(alloc_cnt == a0, "R5/R7 no allocation", 64'(alloc_cnt - a0), 0);
            end
        end

        // R3 spin on lock, R2 refusal of a second miss while busy
        host_write(4'd6, 23'h500077);
        host_write(4'd7, 23'h100042);
        c0 = cas_cnt;
        send_miss(4'd6, 2'd2);
        @(negedge clk);
        miss_valid = 1'b1; miss_pte_addr = PW'(7); miss_core = 2'd3;
        repeat (3) @(negedge clk);
        check(!miss_ready, "R2 busy refuses miss", 64'(miss_ready), 0);
        repeat (8) @(negedge clk);
        miss_valid = 1'b0;
        check(!fill_valid, "R3 no fill while locked", 64'(fill_valid), 0);
        check(cas_cnt == c0, "R3 no swap while locked", 64'(cas_cnt - c0), 0);
        host_write(4'd6, 23'h100077);
        wait_fill(200, seen);
        check(seen && fill_addr == 20'h77 && res_core == 2'd2, "R3 fill after unlock",
              64'({res_core, fill_addr}), 64'({2'd2, 20'h77}));
        w0 = wr_cnt;
        repeat (10) @(negedge clk);
        check(!fill_valid && miss_ready && mem[7] == 23'h100042 && wr_cnt == w0, "R2 refused miss had no effect",
              64'(mem[7]), 64'(23'h100042));

        // R4 swap loses to another lock holder
        host_write(4'd8, 23'h000033);
        c0 = cas_cnt;
        a0 = alloc_cnt;
        steal_req = steal_req + 1;
        send_miss(4'd8, 2'd1);
        repeat (15) @(negedge clk);
        check(!fill_valid && cas_cnt == c0 + 1, "R4 failed swap returns to spin",
              64'(cas_cnt - c0), 1);
        check(alloc_cnt == a0, "R4 no allocation before lock", 64'(alloc_cnt - a0), 0);
        host_write(4'd8, 23'h000033);
        wait_fill(200, seen);
        check(seen && fill_addr == 20'h102 && fill_cached, "R4 retry allocates",
              64'(fill_addr), 64'(20'h102));
        check(cas_cnt == c0 + 2, "R4 second swap", 64'(cas_cnt - c0), 2);
        @(negedge clk);
        check(mem[8] == 23'h100102, "R6 entry rewritten after retry", 64'(mem[8]), 64'(23'h100102));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule